// File: doc/BRIEF.md
# Two-Group Biased Round-Robin Bus Arbiter

This block decides which of six commanders owns a shared bus: four processor requesters and two I/O requesters. Processors and I/O nodes form two groups, each with its own round-robin ring. When both groups have work, ownership alternates between them. Within a group, ownership rotates among the members that are asking. When the bus is idle and both groups ask at once, the processor group is preferred.

Each requester raises its request line and waits for its bit of the one-hot grant. The owner keeps the grant until the tenure-done strobe arrives. In that cycle the arbiter picks the next owner, and the new grant appears on the following clock edge. If nobody is asking, the bus goes idle instead. While the bus is idle, the first cycle with any request starts a new decision.

Top module: `bus_arb_top`

## Requirements
- R1: During and right after reset, every grant bit is 0 and `bus_idle` is 1.
- R2: The combined grant {grant_io, grant_cpu} has at most one bit set. `bus_idle` is 1 exactly when no grant bit is set. A tenure-done strobe with no request pending leaves the bus idle with all grants 0.
- R3: If the bus is idle and any processor request is asserted, the next grant goes to a processor, even when I/O requests are also asserted.
- R4: Processor grants rotate in the order grant_cpu bit 0, 1, 2, 3, then back to bit 0. The search starts after the last processor granted.
- R5: I/O grants alternate between grant_io bit 0 and bit 1. The search starts after the last I/O node granted.
- R6: When a tenure ends and both groups have requests, the grant goes to the group opposite the one that just held the bus.
- R7: When only one group has requests, that group receives consecutive grants in its own rotation order.
- R8: While a grant is held and tenure_done is low, the grant does not change, whatever the requests do.
- R9: A decision is made in a cycle where tenure_done is high while the bus is owned, or in a cycle where a request is present while the bus is idle. Its grant appears on the next clock edge.
- R10: Only an asserted request can be granted. Non-requesting members are skipped. A group's rotation point moves only when a member of that group is granted.
- R11: After reset, with all six requesting and each dropping its request at the end of its second tenure, the grant order is CPU0, IO0, CPU1, IO1, CPU2, IO0, CPU3, IO1, CPU0, CPU1, CPU2, CPU3.
- R12: A tenure_done pulse while the bus is idle and no request is present changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cpu | input | N_CPU | Processor request lines, bit i for processor i |
| req_io | input | N_IO | I/O request lines, bit i for I/O node i |
| tenure_done | input | 1 | Pulse ending the current ownership |
| grant_cpu | output | N_CPU | Processor grant, one-hot or zero |
| grant_io | output | N_IO | I/O grant, one-hot or zero |
| bus_idle | output | 1 | High when no requester owns the bus |

## Verification
Each piece of hidden state has a visible effect on the grants:
- A ring pointer left stale or advanced on the wrong group's grant makes the next grant in that group go to the wrong member. This shows at the first grant after that group's next turn, usually within two tenures.
- A wrong alternation flag sends a grant to the same group twice while the other group is waiting. This shows at the very next tenure boundary.
- A missing idle bias gives the first grant after idle to an I/O node. This shows one cycle after the request appears.

The sweep compares every grant against an arithmetic model, so each of these faults surfaces within a few grants.

// File: rtl/bus_arb_pkg.sv
// Package: shared definitions for the two-group bus arbiter.
// Assumes nothing beyond IEEE 1800-2017.
package bus_arb_pkg;
    // Group that a decision selects.
    typedef enum logic {
        GRP_CPU = 1'b0,
        GRP_IO  = 1'b1
    } arb_grp_e;

    // Index width for a ring of n members (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/bus_arb_ring.sv
// Module: round-robin ring for one requester group.
// Finds the first asserted request at or after the rotation pointer.
// The pointer moves to the member after the winner, but only when
// `advance` says this group was actually granted.
// Assumes N >= 1 and that `advance` is asserted only when `any` is high.
module bus_arb_ring #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] pick,
    output logic         any
);
    localparam int IW = bus_arb_pkg::idx_width(N);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_d;
    logic [IW-1:0] idx;
    logic          found;

    // Search the ring from the pointer and remember the next start point.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        ptr_d = ptr_q;
        idx   = '0;
        for (int off = 0; off < N; off++) begin
            idx = IW'((int'(ptr_q) + off) % N);
            if (!found && req[idx]) begin
                found     = 1'b1;
                pick[idx] = 1'b1;
                ptr_d     = IW'((int'(idx) + 1) % N);
            end
        end
    end

    assign any = |req;

    // Move the rotation pointer when this group wins a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && found) begin
            ptr_q <= ptr_d;
        end
    end
endmodule

// File: rtl/bus_arb_alt.sv
// Module: group alternation between processors and I/O nodes.
// Back-to-back decisions (made at a tenure end) favour the group that did
// not win last. Decisions made from idle always favour processors.
// Assumes `commit` marks every cycle in which a grant is issued.
module bus_arb_alt (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_any,
    input  logic io_any,
    input  logic from_busy,
    input  logic commit,
    output logic pick_io
);
    import bus_arb_pkg::*;

    arb_grp_e pref_q;

    // Choose the group: I/O only if alone, or if it is its turn at a tenure end.
    always_comb begin
        pick_io = io_any && (!cpu_any || (from_busy && (pref_q == GRP_IO)));
    end

    // Hand preference to the opposite group after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pref_q <= GRP_CPU;
        end else if (commit) begin
            pref_q <= pick_io ? GRP_CPU : GRP_IO;
        end
    end
endmodule

// File: rtl/bus_arb_top.sv
// Module: two-group biased round-robin bus arbiter.
// Holds a registered one-hot grant until tenure_done. It decides at a
// tenure end, or on the first request while idle. The new grant is visible
// one clock later.
// Assumes tenure_done is a single-cycle pulse issued by the bus owner.
module bus_arb_top #(
    parameter int N_CPU = 4,
    parameter int N_IO  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CPU-1:0] req_cpu,
    input  logic [N_IO-1:0]  req_io,
    input  logic             tenure_done,
    output logic [N_CPU-1:0] grant_cpu,
    output logic [N_IO-1:0]  grant_io,
    output logic             bus_idle
);
    localparam int NT = N_CPU + N_IO;

    logic [N_CPU-1:0] cpu_pick;
    logic [N_IO-1:0]  io_pick;
    logic             cpu_any;
    logic             io_any;
    logic             pick_io;
    logic             busy_q;
    logic             decide;
    logic             commit;
    logic [NT-1:0]    grant_q;
    logic [NT-1:0]    grant_d;

    // Decision trigger: end of tenure while owned, or any request while idle.
    always_comb begin
        decide = busy_q ? tenure_done : (cpu_any || io_any);
        commit = decide && (cpu_any || io_any);
    end

    bus_arb_ring #(.N(N_CPU)) u_cpu_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_cpu),
        .advance (commit && !pick_io),
        .pick    (cpu_pick),
        .any     (cpu_any)
    );

    bus_arb_ring #(.N(N_IO)) u_io_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_io),
        .advance (commit && pick_io),
        .pick    (io_pick),
        .any     (io_any)
    );

    bus_arb_alt u_alt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_any   (cpu_any),
        .io_any    (io_any),
        .from_busy (busy_q),
        .commit    (commit),
        .pick_io   (pick_io)
    );

    // Form the candidate grant vector from the chosen group's ring.
    always_comb begin
        if (!commit) begin
            grant_d = '0;
        end else if (pick_io) begin
            grant_d = {io_pick, {N_CPU{1'b0}}};
        end else begin
            grant_d = {{N_IO{1'b0}}, cpu_pick};
        end
    end

    // Register ownership; it changes only on a decision cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            busy_q  <= 1'b0;
        end else if (decide) begin
            grant_q <= grant_d;
            busy_q  <= commit;
        end
    end

    assign grant_cpu = grant_q[N_CPU-1:0];
    assign grant_io  = grant_q[NT-1:N_CPU];
    assign bus_idle  = !busy_q;
endmodule

// File: rtl/bus_arb_chk.sv
// Module: property checker for bus_arb_top, attached with bind.
// Watches only the ports of the arbiter.
module bus_arb_chk #(
    parameter int N_CPU = 4,
    parameter int N_IO  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_CPU-1:0] req_cpu,
    input logic [N_IO-1:0]  req_io,
    input logic             tenure_done,
    input logic [N_CPU-1:0] grant_cpu,
    input logic [N_IO-1:0]  grant_io,
    input logic             bus_idle
);
    logic [N_CPU+N_IO-1:0] g_all;
    logic [N_CPU+N_IO-1:0] r_all;
    assign g_all = {grant_io, grant_cpu};
    assign r_all = {req_io, req_cpu};

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(g_all));

    assert_idle_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle == (g_all == '0));

    assert_cpu_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && (|req_cpu)) |=> (|grant_cpu));

    assert_alt_to_io_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && tenure_done && (|grant_cpu) && (|req_io)) |=> (|grant_io));

    assert_alt_to_cpu_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && tenure_done && (|grant_io) && (|req_cpu)) |=> (|grant_cpu));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_idle && !tenure_done) |=> $stable(g_all));

    assert_idle_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && (|r_all)) |=> !bus_idle);

    assert_idle_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && !(|r_all)) |=> bus_idle);

    assert_only_requester_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_idle && (|r_all)) |=> (|(g_all & $past(r_all))));
endmodule

bind bus_arb_top bus_arb_chk #(.N_CPU(N_CPU), .N_IO(N_IO)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_cpu     (req_cpu),
    .req_io      (req_io),
    .tenure_done (tenure_done),
    .grant_cpu   (grant_cpu),
    .grant_io    (grant_io),
    .bus_idle    (bus_idle)
);

// File: tb/tb_bus_arb_top.sv
`timescale 1ns/1ps
module tb_bus_arb_top;
    localparam int NC = 4;
    localparam int NI = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req_cpu = '0;
    logic [NI-1:0] req_io = '0;
    logic          tenure_done = 1'b0;
    logic [NC-1:0] grant_cpu;
    logic [NI-1:0] grant_io;
    logic          bus_idle;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_arb_top #(.N_CPU(NC), .N_IO(NI)) dut (
        .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .req_io(req_io),
        .tenure_done(tenure_done), .grant_cpu(grant_cpu),
        .grant_io(grant_io), .bus_idle(bus_idle)
    );

    // Record one comparison of actual against expected.
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply reset for a few cycles and leave inputs quiet.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_cpu = '0; req_io = '0; tenure_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Combined grant value {grant_io, grant_cpu}.
    function automatic int gvec();
        return int'({grant_io, grant_cpu});
    endfunction

    // Round-robin pick among n members starting at ptr; returns index or -1.
    function automatic int rr(input int req, input int ptr, input int n);
        for (int k = 0; k < n; k++) begin
            if (req[(ptr + k) % n]) return (ptr + k) % n;
        end
        return -1;
    endfunction

    // Directed run of the six-way two-tenure sequence.
    task automatic seq_test();
        int exp_seq[12] = '{0, 4, 1, 5, 2, 4, 3, 5, 0, 1, 2, 3};
        int cnt[6] = '{0, 0, 0, 0, 0, 0};
        logic [5:0] r;
        r = 6'h3f;
        @(negedge clk);
        req_cpu = r[3:0]; req_io = r[5:4];
        @(negedge clk);
        check("R3 R11 first grant", gvec(), 1 << exp_seq[0]);
        for (int s = 1; s < 13; s++) begin
            for (int b = 0; b < 6; b++) begin
                if (gvec() == (1 << b)) begin
                    cnt[b]++;
                    if (cnt[b] == 2) r[b] = 1'b0;
                end
            end
            req_cpu = r[3:0]; req_io = r[5:4]; tenure_done = 1'b1;
            @(negedge clk);
            tenure_done = 1'b0;
            if (s < 12) check($sformatf("R11 R6 R7 grant %0d", s + 1), gvec(), 1 << exp_seq[s]);
        end
        check("R2 idle after last tenure", int'(bus_idle), 1);
        check("R2 grant zero when no request", gvec(), 0);
    endtask

    // Hold, idle-ignore and start-latency checks.
    task automatic hold_test();
        // R12: tenure_done while idle with no requests.
        tenure_done = 1'b1;
        @(negedge clk);
        tenure_done = 1'b0;
        check("R12 idle pulse ignored grant", gvec(), 0);
        check("R12 idle pulse ignored idle", int'(bus_idle), 1);
        // R9: request while idle -> grant one edge later. R10: lone IO1.
        req_io = 2'b10;
        @(negedge clk);
        check("R9 R10 idle start grant", gvec(), 1 << 5);
        // R8: grant holds while requests change and no tenure_done.
        req_io = 2'b00; req_cpu = 4'b1111;
        repeat (4) @(negedge clk);
        check("R8 grant held", gvec(), 1 << 5);
        req_cpu = 4'b0000;
        repeat (2) @(negedge clk);
        check("R8 grant held no requests", gvec(), 1 << 5);
        tenure_done = 1'b1;
        @(negedge clk);
        tenure_done = 1'b0;
        check("R9 R2 release to idle", int'(bus_idle), 1);
    endtask

    // Sweep request patterns, comparing to an arithmetic model.
    task automatic sweep();
        int cp = 0;
        int ip = 0;
        bit pref_io = 1'b0;
        bit busy = 1'b0;
        int exp_g = 0;
        for (int st = 0; st < 600; st++) begin
            int pat;
            int cr;
            int ir;
            bit take_io;
            int w;
            pat = (st * 37 + st / 64 * 5 + 11) % 64;
            if (st % 9 == 0) pat = 0;
            cr = pat & 15;
            ir = pat >> 4;
            req_cpu = 4'(cr); req_io = 2'(ir);
            tenure_done = busy;
            if (pat != 0) begin
                take_io = (ir != 0) && ((cr == 0) || (busy && pref_io));
                if (take_io) begin
                    w = rr(ir, ip, NI);
                    ip = (w + 1) % NI;
                    exp_g = 1 << (NC + w);
                    pref_io = 1'b0;
                end else begin
                    w = rr(cr, cp, NC);
                    cp = (w + 1) % NC;
                    exp_g = 1 << w;
                    pref_io = 1'b1;
                end
                busy = 1'b1;
            end else begin
                exp_g = 0;
                busy = 1'b0;
            end
            @(negedge clk);
            tenure_done = 1'b0;
            check($sformatf("sweep R3 R4 R5 R6 R7 R10 step %0d", st), gvec(), exp_g);
        end
        req_cpu = '0; req_io = '0;
        tenure_done = busy;
        @(negedge clk);
        tenure_done = 1'b0;
        check("sweep R2 final idle", int'(bus_idle), 1);
    endtask

    // Print the summary exactly once.
    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        @(negedge clk);
        check("R1 grant zero in reset", gvec(), 0);
        check("R1 idle in reset", int'(bus_idle), 1);
        do_reset();
        @(negedge clk);
        check("R1 grant zero after reset", gvec(), 0);
        seq_test();
        hold_test();
        do_reset();
        sweep();
        finish_run();
    end
endmodule